// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Read Sequencer

This block runs a six-channel successive-approximation converter that samples all channels at the same instant and returns results over a parallel bus, one full word per read. A conversion starts on a one-cycle start request, or on a periodic tick while automatic mode is enabled. The sequencer raises three convert-start lines together, which makes all six channels sample at one instant. It then watches the converter's busy flag for the end of conversion and guards that wait with a timeout.

Once conversion has ended, chip select goes low and stays low while six read strobes fetch channels 1 to 6 in order. Each result word appears on a one-cycle valid output with its channel index. The convert-start lines stay high from the start of conversion until the sixth word has been taken, and a done pulse follows that word. A trigger that arrives while a sequence is still running is dropped and reported.

States: `ST_IDLE` (bus quiet), `ST_ARM` (convert-start high, waiting for busy to rise or for the minimum delay), `ST_WAIT` (watching for busy low, timeout running), `ST_SETUP` (chip select low, one cycle before the first strobe), `ST_STROBE` (read strobe low), `ST_GAP` (strobe high between reads), `ST_DONE` (convert-start released). Transitions:
- idle to arm, on a trigger.
- arm to wait, when busy is high or the minimum delay has elapsed.
- wait to setup, when busy is low.
- wait to idle, on timeout.
- setup to strobe, always.
- strobe to gap, on the last low cycle of any channel except the final one.
- strobe to done, on the last low cycle of the final channel.
- gap to strobe, once the gap has elapsed.
- done to idle, always.

Top module: `simsamp_adc_seq`

## Requirements
- R1: A trigger starts a sequence. A trigger is `start_i` high, or the periodic tick, sampled while the sequencer is idle. All three convert-start outputs rise together in the following cycle, while chip select and the read strobe are both still high.
- R2: The three convert-start outputs stay equal and stay high through the whole conversion and all six reads. They fall in the same cycle that the sixth word is presented, or in the same cycle that a timeout is reported.
- R3: A low busy input is accepted as end of conversion only after busy has been sampled high, or after MIN_WAIT_CYC cycles of convert-start high. Chip select (active low) falls in the cycle after busy is sampled low in the waiting state, never after a cycle where busy was high.
- R4: Chip select stays low for one setup cycle, then for six read strobes (active low) of RD_LOW_CYC cycles each, separated by RD_GAP_CYC cycles with the strobe high. The read strobe is never low while chip select is high.
- R5: The bus value is latched in the last low cycle of each strobe. `word_valid_o` pulses for one cycle as the strobe rises, with `word_data_o` equal to the latched value. `word_chan_o` counts 0 to 5 in order, where 0 stands for input 1.
- R6: `done_o` pulses for one cycle, in the cycle after the sixth word. Chip select is high and the sequencer is idle by then.
- R7: If busy is still high TIMEOUT_CYC cycles after convert-start rose, `timeout_err_o` pulses for one cycle, convert-start falls, no read is issued and the sequencer returns to idle.
- R8: A trigger that arrives in any state other than idle is ignored. It sets `overrun_o` high in the following cycle, once per cycle of trigger, and the running sequence continues unchanged.
- R9: While `auto_en_i` is high, a periodic tick fires every PERIOD_CYC cycles and acts as a trigger. When `auto_en_i` is low, the period counter is held at zero.
- R10: During and right after reset, convert-start is low, chip select and the read strobe are high, and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, one cycle per sequence |
| auto_en_i | input | 1 | Enables the periodic trigger |
| busy_i | input | 1 | Converter busy flag |
| adc_data_i | input | DATA_W (16) | Converter parallel data bus |
| convst_a_o | output | 1 | Convert-start line, channel pair 1 |
| convst_b_o | output | 1 | Convert-start line, channel pair 2 |
| convst_c_o | output | 1 | Convert-start line, channel pair 3 |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| word_valid_o | output | 1 | One-cycle result valid |
| word_chan_o | output | CH_W (3) | Channel index of the result |
| word_data_o | output | DATA_W (16) | Result word |
| done_o | output | 1 | Sequence complete pulse |
| timeout_err_o | output | 1 | Conversion timeout pulse |
| overrun_o | output | 1 | Trigger dropped while busy |

## Verification
The bound checker watches the bus relations on every cycle:
- the read strobe only appears under chip select;
- chip select only appears with convert-start high;
- chip select only falls after busy was sampled low;
- each word arrives as its strobe is released;
- done follows the last channel;
- convert-start only falls on completion or on a timeout.

Some behaviour only the bench scenarios can show. These include the exact timing of the strobes and gaps, the channel order and data per sample, and the minimum-delay path when busy never rises. They also include the timeout length, trigger drops while running or in the done state, and the periodic tick rate. The bench checks these against its own cycle model and a converter model whose busy flag rises late, never rises, or sticks high.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_GAP,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/simsamp_tick.sv
// Periodic trigger: one-cycle tick every PERIOD_CYC cycles while enabled.
module simsamp_tick #(
    parameter int PERIOD_CYC = 2000,
    localparam int W = $clog2(PERIOD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam logic [W-1:0] LAST = W'(PERIOD_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/simsamp_span.sv
// Free-running cycle counter with synchronous clear.
module simsamp_span #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/simsamp_adc_seq.sv
module simsamp_adc_seq
    import simsamp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_CH      = 6,
    parameter int MIN_WAIT_CYC = 8,
    parameter int TIMEOUT_CYC = 1500,
    parameter int RD_LOW_CYC  = 3,
    parameter int RD_GAP_CYC  = 2,
    parameter int PERIOD_CYC  = 2000,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              convst_a_o,
    output logic              convst_b_o,
    output logic              convst_c_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              word_valid_o,
    output logic [CH_W-1:0]   word_chan_o,
    output logic [DATA_W-1:0] word_data_o,
    output logic              done_o,
    output logic              timeout_err_o,
    output logic              overrun_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam int PH_MAX = (RD_LOW_CYC > RD_GAP_CYC) ? RD_LOW_CYC : RD_GAP_CYC;
    localparam int PH_W = $clog2(PH_MAX + 1);
    localparam logic [CNT_W-1:0] MW_LAST  = CNT_W'(MIN_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [PH_W-1:0]  LOW_LAST = PH_W'(RD_LOW_CYC - 1);
    localparam logic [PH_W-1:0]  GAP_LAST = PH_W'(RD_GAP_CYC - 1);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

    seq_state_t state_q, state_d;

    logic             tick;
    logic             trig;
    logic             conv_clr;
    logic             ph_clr;
    logic [CNT_W-1:0] conv_cnt;
    logic [PH_W-1:0]  ph_cnt;
    logic [CH_W-1:0]  ch_q;
    logic             timeout_hit;
    logic             last_low;

    // Outputs decoded from state
    logic conv_on;
    logic cs_on;
    logic rd_on;

    simsamp_tick #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en_i),
        .tick_o (tick)
    );

    assign conv_clr = !(state_q == ST_ARM || state_q == ST_WAIT);

    simsamp_span #(.W(CNT_W)) u_conv_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (conv_clr),
        .cnt_o (conv_cnt)
    );

    assign ph_clr = (state_d != state_q);

    simsamp_span #(.W(PH_W)) u_phase_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ph_clr),
        .cnt_o (ph_cnt)
    );

    assign trig        = start_i || tick;
    assign timeout_hit = busy_i && (conv_cnt >= TO_LAST);
    assign last_low    = (ph_cnt == LOW_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (busy_i || (conv_cnt >= MW_LAST)) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!busy_i) begin
                    state_d = ST_SETUP;
                end else if (timeout_hit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SETUP: begin
                state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (last_low) begin
                    state_d = (ch_q == CH_LAST) ? ST_DONE : ST_GAP;
                end
            end
            ST_GAP: begin
                if (ph_cnt == GAP_LAST) state_d = ST_STROBE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        conv_on = 1'b0;
        cs_on   = 1'b0;
        rd_on   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARM:    conv_on = 1'b1;
            ST_WAIT:   conv_on = 1'b1;
            ST_SETUP:  begin conv_on = 1'b1; cs_on = 1'b1; end
            ST_STROBE: begin conv_on = 1'b1; cs_on = 1'b1; rd_on = 1'b1; end
            ST_GAP:    begin conv_on = 1'b1; cs_on = 1'b1; end
            ST_DONE:   ;
            default:   ;
        endcase
    end

    assign convst_a_o = conv_on;
    assign convst_b_o = conv_on;
    assign convst_c_o = conv_on;
    assign cs_n_o     = !cs_on;
    assign rd_n_o     = !rd_on;

    // Channel index
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            ch_q <= '0;
        end else if (state_q == ST_GAP && state_d == ST_STROBE) begin
            ch_q <= ch_q + 1'b1;
        end
    end

    // Result capture and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid_o  <= 1'b0;
            word_chan_o   <= '0;
            word_data_o   <= '0;
            done_o        <= 1'b0;
            timeout_err_o <= 1'b0;
            overrun_o     <= 1'b0;
        end else begin
            word_valid_o  <= (state_q == ST_STROBE) && last_low;
            if ((state_q == ST_STROBE) && last_low) begin
                word_chan_o <= ch_q;
                word_data_o <= adc_data_i;
            end
            done_o        <= (state_q == ST_DONE);
            timeout_err_o <= (state_q == ST_WAIT) && timeout_hit;
            overrun_o     <= trig && (state_q != ST_IDLE);
        end
    end

endmodule

// File: rtl/simsamp_adc_seq_chk.sv
module simsamp_adc_seq_chk #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_i,
    input logic            convst_a_o,
    input logic            convst_b_o,
    input logic            convst_c_o,
    input logic            cs_n_o,
    input logic            rd_n_o,
    input logic            word_valid_o,
    input logic [CH_W-1:0] word_chan_o,
    input logic            done_o,
    input logic            timeout_err_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    assert_start_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_a_o) |-> cs_n_o && rd_n_o);

    assert_cs_under_convst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> convst_a_o && convst_b_o && convst_c_o);

    assert_convst_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_a_o) |-> timeout_err_o || (word_valid_o && word_chan_o == LAST_CH));

    assert_cs_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !$past(busy_i));

    assert_rd_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);

    assert_word_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> rd_n_o && !$past(rd_n_o));

    assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> word_chan_o <= LAST_CH);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(word_valid_o) && ($past(word_chan_o) == LAST_CH) && cs_n_o);

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> !convst_a_o && cs_n_o && rd_n_o);

endmodule

bind simsamp_adc_seq simsamp_adc_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (.*);

// File: tb/simsamp_adc_seq_test.sv
module simsamp_adc_seq_test;
    localparam int NCH  = 6;
    localparam int MW   = 4;
    localparam int TO   = 60;
    localparam int RDL  = 3;
    localparam int GAP  = 2;
    localparam int PER  = 200;
    localparam int CONV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        auto_en_i = 1'b0;
    logic        busy_i = 1'b0;
    logic [15:0] adc_data_i = '0;
    logic        convst_a_o, convst_b_o, convst_c_o, cs_n_o, rd_n_o;
    logic        word_valid_o, done_o, timeout_err_o, overrun_o;
    logic [2:0]  word_chan_o;
    logic [15:0] word_data_o;

    always #2 clk = ~clk;

    simsamp_adc_seq #(
        .DATA_W(16), .NUM_CH(NCH), .MIN_WAIT_CYC(MW), .TIMEOUT_CYC(TO),
        .RD_LOW_CYC(RDL), .RD_GAP_CYC(GAP), .PERIOD_CYC(PER)
    ) uut (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    int m_st, m_cnt, m_p, m_ch, m_tick;
    bit e_valid, e_done, e_err, e_ovr;
    int e_chan;
    // Converter model
    int busy_mode = 0;
    int adc_t, sample, rd_idx, seq_words;
    bit prev_rd;
    // Observed totals
    int n_words, n_done, n_err, n_ovr;

    function automatic logic [15:0] pat(int s, int c);
        return 16'(((s * 16) + c) ^ 'h5A00);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_p = 0; m_ch = 0; m_tick = 0;
            e_valid = 0; e_done = 0; e_err = 0; e_ovr = 0; e_chan = 0;
            adc_t = 0; rd_idx = 0; prev_rd = 1; seq_words = 0;
            chk(!convst_a_o && !convst_b_o && !convst_c_o, "R10", "convst in reset", convst_a_o, 0);
            chk(cs_n_o && rd_n_o, "R10", "cs_n/rd_n in reset", {cs_n_o, rd_n_o}, 3);
            chk(!word_valid_o && !done_o && !timeout_err_o && !overrun_o, "R10", "pulses in reset",
                {word_valid_o, done_o, timeout_err_o, overrun_o}, 0);
        end else begin
            bit exp_conv, exp_cs, exp_rd, trig;
            int nst;
            exp_conv = (m_st >= 1 && m_st <= 5);
            exp_cs   = (m_st >= 3 && m_st <= 5);
            exp_rd   = (m_st == 4);
            chk(convst_a_o == exp_conv && convst_b_o == exp_conv && convst_c_o == exp_conv,
                "R2", "convst lines", {convst_a_o, convst_b_o, convst_c_o}, exp_conv ? 7 : 0);
            chk(cs_n_o == !exp_cs, "R3", "cs_n", cs_n_o, !exp_cs);
            chk(rd_n_o == !exp_rd, "R4", "rd_n", rd_n_o, !exp_rd);
            chk(word_valid_o == e_valid, "R5", "word_valid", word_valid_o, e_valid);
            chk(done_o == e_done, "R6", "done", done_o, e_done);
            chk(timeout_err_o == e_err, "R7", "timeout_err", timeout_err_o, e_err);
            chk(overrun_o == e_ovr, "R8", "overrun", overrun_o, e_ovr);
            if (word_valid_o) begin
                n_words++;
                chk(int'(word_chan_o) == e_chan, "R5", "chan vs model", word_chan_o, e_chan);
                chk(int'(word_chan_o) == seq_words, "R5", "chan order", word_chan_o, seq_words);
                chk(word_data_o == pat(sample, int'(word_chan_o)), "R5", "data",
                    word_data_o, pat(sample, int'(word_chan_o)));
                seq_words++;
            end
            if (done_o) n_done++;
            if (timeout_err_o) n_err++;
            if (overrun_o) n_ovr++;

            // Converter model: drives busy and data for the next edge
            if (convst_a_o) adc_t++; else adc_t = 0;
            if (adc_t == 1) begin sample++; seq_words = 0; end
            case (busy_mode)
                0: busy_i = (adc_t >= 2 && adc_t < 2 + CONV);
                1: busy_i = 1'b0;
                default: busy_i = (adc_t >= 2);
            endcase
            if (cs_n_o) rd_idx = 0;
            else if (!rd_n_o && prev_rd) rd_idx++;
            prev_rd = rd_n_o;
            adc_data_i = pat(sample, rd_idx - 1);

            // Reference model step (inputs as sampled at the next rising edge)
            trig = start_i || (auto_en_i && m_tick == PER - 1);
            e_ovr   = trig && (m_st != 0);
            e_err   = (m_st == 2) && busy_i && (m_cnt >= TO - 1);
            e_valid = (m_st == 4) && (m_p == RDL - 1);
            if (e_valid) e_chan = m_ch;
            e_done  = (m_st == 6);
            case (m_st)
                0: nst = trig ? 1 : 0;
                1: nst = (busy_i || m_cnt >= MW - 1) ? 2 : 1;
                2: nst = !busy_i ? 3 : ((m_cnt >= TO - 1) ? 0 : 2);
                3: nst = 4;
                4: nst = (m_p == RDL - 1) ? ((m_ch == NCH - 1) ? 6 : 5) : 4;
                5: nst = (m_p == GAP - 1) ? 4 : 5;
                default: nst = 0;
            endcase
            if (m_st == 0) m_ch = 0;
            else if (m_st == 5 && nst == 4) m_ch++;
            m_cnt  = (m_st == 1 || m_st == 2) ? m_cnt + 1 : 0;
            m_p    = (nst != m_st) ? 0 : m_p + 1;
            m_tick = !auto_en_i ? 0 : ((m_tick == PER - 1) ? 0 : m_tick + 1);
            m_st   = nst;
        end
    end

    task automatic pulse_start(int len);
        @(posedge clk); #1 start_i = 1'b1;
        repeat (len) @(posedge clk);
        #1 start_i = 1'b0;
    endtask

    task automatic idle_wait(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int w0, d0, e0, o0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // Normal conversion, busy rises late (R1, R3, R4, R5, R6)
        pulse_start(1); idle_wait(120);
        chk(n_words == 6, "R5", "words after normal run", n_words, 6);
        chk(n_done == 1, "R6", "done count", n_done, 1);

        // Busy never rises: minimum delay path (R3)
        busy_mode = 1; w0 = n_words;
        pulse_start(1); idle_wait(120);
        chk(n_words - w0 == 6, "R3", "words with silent busy", n_words - w0, 6);

        // Busy stuck high: timeout (R7)
        busy_mode = 2; w0 = n_words; e0 = n_err;
        pulse_start(1); idle_wait(120);
        chk(n_err - e0 == 1, "R7", "timeout count", n_err - e0, 1);
        chk(n_words == w0, "R7", "no words on timeout", n_words - w0, 0);

        // Trigger during a running sequence (R8)
        busy_mode = 0; d0 = n_done; o0 = n_ovr;
        pulse_start(1); idle_wait(10); pulse_start(1); idle_wait(120);
        chk(n_done - d0 == 1, "R8", "one sequence despite retrigger", n_done - d0, 1);
        chk(n_ovr - o0 == 1, "R8", "overrun count", n_ovr - o0, 1);

        // Start held for three cycles: first accepted, rest dropped (R1, R8)
        d0 = n_done; o0 = n_ovr;
        pulse_start(3); idle_wait(120);
        chk(n_done - d0 == 1, "R1", "held start gives one sequence", n_done - d0, 1);
        chk(n_ovr - o0 == 2, "R8", "overrun for held start", n_ovr - o0, 2);

        // Periodic trigger (R9)
        d0 = n_done;
        @(posedge clk); #1 auto_en_i = 1'b1;
        idle_wait(2 * PER + 20);
        #1 auto_en_i = 1'b0;
        idle_wait(150);
        chk(n_done - d0 == 2, "R9", "periodic sequences", n_done - d0, 2);
        d0 = n_done;
        idle_wait(PER + 20);
        chk(n_done == d0, "R9", "no tick when disabled", n_done - d0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule